// File: doc/BRIEF.md
# SDRAM Mode Command Sequencer

This block takes one command at a time from a software command register and places it on the command pins of up to two SDRAM devices. Each command carries a 3-bit mode, a repeat count for auto-refresh, a two-bit device target mask and a mode-register value. The block drives the clock enable, one chip select per device, the row strobe, column strobe and write enable, the bank address and the address bus. While a command and its recovery time are in progress it reports busy.

Software brings the memory up by enabling the clock, waiting out the device start-up time, and then issuing a precharge-all, a burst of auto-refreshes (normally eight from a single write) and a mode-register load. After each command the block holds busy for the recovery time that the timing inputs give. Every timing input holds the cycle count minus one. The row-cycle and row-precharge times are shared by both devices. The mode-register-to-active time is set per device, and a load aimed at several devices waits for the longest of their times. The block then accepts self-refresh, power-down and normal-mode commands to move the devices between their power states.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, sdCke is 0, both sdCsN bits are 1, sdRasN, sdCasN and sdWeN are 1, busy is 0 and wrErr is 0.
- R2: Mode 2 (precharge all) drives sdRasN=0, sdCasN=1, sdWeN=0, and sdAddr with only bit 10 set.
- R3: Mode 3 (auto-refresh) drives sdRasN=0, sdCasN=0, sdWeN=1. A count field c issues c refreshes, and a count of 0 issues one. Consecutive refreshes from one write are exactly tRc+1 cycles apart.
- R4: Mode 4 (load mode) drives sdRasN, sdCasN and sdWeN all 0, with sdAddr equal to cmdMrVal and sdBa equal to 0.
- R5: cmdTgt bit 0 selects device 0 (sdCsN[0] low), and bit 1 selects device 1 (sdCsN[1] low). Either bit alone or both together may be set.
- R6: A write accepted while busy is 0 raises busy in the next cycle. busy then stays high for tRp+1 cycles for mode 2, c*(tRc+1) cycles for mode 3, and 1 plus the largest tMrd field among the targeted devices for mode 4. All other modes hold busy for 1 cycle.
- R7: A command appears on the pins only in the single cycle that follows the accepting edge, or the edge of a refresh repeat. In every other cycle both chip selects are high and sdRasN, sdCasN and sdWeN are high.
- R8: sdCke stays 0 from reset until a mode 1 (clock enable) or mode 0 (normal) command, and either of those sets it to 1. Mode 5 (self-refresh) drives the auto-refresh pin pattern with sdCke=0 in the same cycle. Mode 6 (power-down) sets sdCke to 0 with no chip select.
- R9: A write while busy is 1 is ignored: it puts no command on the pins and does not extend busy. It sets wrErr, which stays 1 until reset.
- R10: Mode 7 is a no-operation. It drives no chip select, leaves sdCke unchanged and holds busy for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cmdWr | input | 1 | Command register write strobe |
| cmdMode | input | 3 | Command mode |
| cmdRefCnt | input | REF_CNT_W | Auto-refresh repeat count |
| cmdTgt | input | 2 | Device target mask |
| cmdMrVal | input | ADDR_W | Mode register value for load mode |
| tRc | input | TIM_W | Row-cycle time minus one (shared) |
| tRp | input | TIM_W | Row-precharge time minus one (shared) |
| tMrd | input | 2*TIM_W | Per-device mode-register-to-active time minus one, device 0 in the low field |
| sdCke | output | 1 | Clock enable |
| sdCsN | output | 2 | Per-device chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BA_W | Bank address |
| sdAddr | output | ADDR_W | Address bus |
| busy | output | 1 | Command in progress |
| wrErr | output | 1 | Sticky flag: write arrived while busy |

## Verification
A command's pin pattern is due in the cycle right after the edge that accepts the write. busy rises on that same edge and falls after the recovery count given in R6. Refresh repeats follow at intervals of exactly tRc+1 cycles. The driver pushes each expected pin pattern into a queue, together with the spacing it expects from the previous pattern. A monitor samples on every falling edge and counts cycles between selected commands, so it checks both the content and the cycle of each command. Any chip select seen with the queue empty counts as a failure. The driver counts busy cycles after each write and compares the count with the R6 formula, and it reads sdCke and wrErr only after busy has dropped.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int DEV_COUNT = 2;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_CKEN   = 3'd1,
    MODE_PALL   = 3'd2,
    MODE_AREF   = 3'd3,
    MODE_LMR    = 3'd4,
    MODE_SREF   = 3'd5,
    MODE_PDN    = 3'd6,
    MODE_NOP    = 3'd7
  } sdModeE;

  typedef struct packed {
    logic                 issue;
    sdModeE               mode;
    logic [DEV_COUNT-1:0] tgt;
  } seqStrobeT;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int REF_CNT_W = 4,
  parameter int TIM_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdWr,
  input  logic [2:0]                 cmdMode,
  input  logic [REF_CNT_W-1:0]       cmdRefCnt,
  input  logic [DEV_COUNT-1:0]       cmdTgt,
  input  logic [TIM_W-1:0]           tRc,
  input  logic [TIM_W-1:0]           tRp,
  input  logic [DEV_COUNT*TIM_W-1:0] tMrd,
  output seqStrobeT                  stb,
  output logic                       busy,
  output logic                       wrErr
);

  typedef enum logic {ST_IDLE, ST_WAIT} stateE;

  stateE                 state;
  logic [TIM_W-1:0]      waitCnt;
  logic [REF_CNT_W-1:0]  refLeft;
  logic [DEV_COUNT-1:0]  capTgt;
  logic [TIM_W-1:0]      mrdMax;
  logic [TIM_W-1:0]      startDelay;
  logic                  accept;
  logic                  repeatRef;
  sdModeE                inMode;

  assign inMode    = sdModeE'(cmdMode);
  assign accept    = (state == ST_IDLE) && cmdWr;
  assign repeatRef = (state == ST_WAIT) && (waitCnt == '0) && (refLeft != '0);
  assign busy      = (state != ST_IDLE);

  // Longest mode-register-to-active time among the targeted devices
  always_comb begin
    mrdMax = '0;
    for (int d = 0; d < DEV_COUNT; d++) begin
      if (cmdTgt[d] && (tMrd[d*TIM_W +: TIM_W] > mrdMax))
        mrdMax = tMrd[d*TIM_W +: TIM_W];
    end
  end

  always_comb begin
    case (inMode)
      MODE_PALL: startDelay = tRp;
      MODE_AREF: startDelay = tRc;
      MODE_LMR:  startDelay = mrdMax;
      default:   startDelay = '0;
    endcase
  end

  always_comb begin
    stb = '{issue: 1'b0, mode: MODE_NOP, tgt: '0};
    if (accept) begin
      stb.issue = 1'b1;
      stb.mode  = inMode;
      stb.tgt   = cmdTgt;
    end else if (repeatRef) begin
      stb.issue = 1'b1;
      stb.mode  = MODE_AREF;
      stb.tgt   = capTgt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      refLeft <= '0;
      capTgt  <= '0;
      wrErr   <= 1'b0;
    end else begin
      if (cmdWr && state != ST_IDLE) wrErr <= 1'b1;
      case (state)
        ST_IDLE: if (cmdWr) begin
          state   <= ST_WAIT;
          waitCnt <= startDelay;
          capTgt  <= cmdTgt;
          refLeft <= (inMode == MODE_AREF && cmdRefCnt > 1) ? cmdRefCnt - 1'b1 : '0;
        end
        default: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - 1'b1;
          end else if (refLeft != '0) begin
            refLeft <= refLeft - 1'b1;
            waitCnt <= tRc;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  a_r9_err_on_busy_write: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && busy |=> wrErr);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |=> wrErr);
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !busy |=> busy);
  a_r9_no_issue_while_waiting: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && (waitCnt != '0) |-> !stb.issue);

endmodule

// File: rtl/sdram_cmd_dp.sv
module sdram_cmd_dp
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobeT            stb,
  input  logic [ADDR_W-1:0]    cmdMrVal,
  output logic                 sdCke,
  output logic [DEV_COUNT-1:0] sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [BA_W-1:0]      sdBa,
  output logic [ADDR_W-1:0]    sdAddr
);

  localparam int AP_BIT = 10;
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  logic                 selMode;
  logic [DEV_COUNT-1:0] csNext;

  always_comb begin
    case (stb.mode)
      MODE_PALL, MODE_AREF, MODE_LMR, MODE_SREF: selMode = stb.issue;
      default:                                   selMode = 1'b0;
    endcase
  end

  for (genvar d = 0; d < DEV_COUNT; d++) begin : g_cs
    assign csNext[d] = !(selMode && stb.tgt[d]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdCke  <= 1'b0;
      sdCsN  <= '1;
      sdRasN <= 1'b1;
      sdCasN <= 1'b1;
      sdWeN  <= 1'b1;
      sdBa   <= '0;
      sdAddr <= '0;
    end else begin
      sdCsN  <= csNext;
      sdRasN <= 1'b1;
      sdCasN <= 1'b1;
      sdWeN  <= 1'b1;
      sdBa   <= '0;
      sdAddr <= '0;
      if (stb.issue) begin
        case (stb.mode)
          MODE_NORMAL, MODE_CKEN: sdCke <= 1'b1;
          MODE_PALL: begin
            sdRasN <= 1'b0;
            sdWeN  <= 1'b0;
            sdAddr <= ALL_BANKS;
          end
          MODE_AREF: begin
            sdRasN <= 1'b0;
            sdCasN <= 1'b0;
          end
          MODE_LMR: begin
            sdRasN <= 1'b0;
            sdCasN <= 1'b0;
            sdWeN  <= 1'b0;
            sdAddr <= cmdMrVal;
          end
          MODE_SREF: begin
            sdRasN <= 1'b0;
            sdCasN <= 1'b0;
            sdCke  <= 1'b0;
          end
          MODE_PDN: sdCke <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  a_r8_cke_held_low: assert property (@(posedge clk) disable iff (!rstN)
    !sdCke && !(stb.issue && (stb.mode == MODE_CKEN || stb.mode == MODE_NORMAL)) |=> !sdCke);
  a_r5_cs_follows_target: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue && stb.mode == MODE_PALL |=> sdCsN == ~$past(stb.tgt));
  a_r10_nop_no_select: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue && stb.mode == MODE_NOP |=> (&sdCsN) && $stable(sdCke));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int REF_CNT_W = 4,
  parameter int TIM_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdWr,
  input  logic [2:0]                 cmdMode,
  input  logic [REF_CNT_W-1:0]       cmdRefCnt,
  input  logic [1:0]                 cmdTgt,
  input  logic [ADDR_W-1:0]          cmdMrVal,
  input  logic [TIM_W-1:0]           tRc,
  input  logic [TIM_W-1:0]           tRp,
  input  logic [2*TIM_W-1:0]         tMrd,
  output logic                       sdCke,
  output logic [1:0]                 sdCsN,
  output logic                       sdRasN,
  output logic                       sdCasN,
  output logic                       sdWeN,
  output logic [BA_W-1:0]            sdBa,
  output logic [ADDR_W-1:0]          sdAddr,
  output logic                       busy,
  output logic                       wrErr
);

  seqStrobeT stb;

  sdram_cmd_ctrl #(.REF_CNT_W(REF_CNT_W), .TIM_W(TIM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdMode(cmdMode),
    .cmdRefCnt(cmdRefCnt), .cmdTgt(cmdTgt), .tRc(tRc), .tRp(tRp),
    .tMrd(tMrd), .stb(stb), .busy(busy), .wrErr(wrErr)
  );

  sdram_cmd_dp #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdMrVal(cmdMrVal),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr)
  );

  a_r7_idle_deselect: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&sdCsN));
  a_r2_precharge_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && sdCasN && !sdWeN && !(&sdCsN) && tRp != '0) |=> (&sdCsN));

endmodule

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;

  localparam int ADDR_W = 13;
  localparam int TIM_W  = 4;
  localparam int RC = 5, RP = 2, MRD0 = 1, MRD1 = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWr = 1'b0;
  logic [2:0] cmdMode = '0;
  logic [3:0] cmdRefCnt = '0;
  logic [1:0] cmdTgt = '0;
  logic [ADDR_W-1:0] cmdMrVal = '0;
  logic [TIM_W-1:0] tRc = RC, tRp = RP;
  logic [2*TIM_W-1:0] tMrd = {4'(MRD1), 4'(MRD0)};
  logic sdCke, sdRasN, sdCasN, sdWeN, busy, wrErr;
  logic [1:0] sdCsN, sdBa;
  logic [ADDR_W-1:0] sdAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic ckeExp = 1'b0;

  typedef struct {
    logic [1:0] csN;
    logic [2:0] rcw;
    logic [ADDR_W-1:0] addr;
    logic cke;
    int gap;
    string req;
  } evT;
  evT expQ[$];

  always #2.5 clk = ~clk;

  sdram_cmd_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdMode(cmdMode),
    .cmdRefCnt(cmdRefCnt), .cmdTgt(cmdTgt), .cmdMrVal(cmdMrVal),
    .tRc(tRc), .tRp(tRp), .tMrd(tMrd), .sdCke(sdCke), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa),
    .sdAddr(sdAddr), .busy(busy), .wrErr(wrErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: compare every selected command against the scoreboard
  int gapCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      gapCnt++;
      if (sdCsN != 2'b11) begin
        if (expQ.size() == 0) begin
          chk(0, "R7 unexpected command", {28'h0, sdCsN, sdRasN, sdCasN}, 32'h3);
        end else begin
          evT e;
          e = expQ.pop_front();
          chk(sdCsN == e.csN, {e.req, " chip select"}, 32'(sdCsN), 32'(e.csN));
          chk({sdRasN, sdCasN, sdWeN} == e.rcw, {e.req, " ras/cas/we"}, 32'({sdRasN, sdCasN, sdWeN}), 32'(e.rcw));
          chk(sdAddr == e.addr && sdBa == 2'b00, {e.req, " address"}, 32'(sdAddr), 32'(e.addr));
          chk(sdCke == e.cke, {e.req, " cke with command"}, 32'(sdCke), 32'(e.cke));
          if (e.gap != 0) chk(gapCnt == e.gap, "R3 refresh spacing", 32'(gapCnt), 32'(e.gap));
        end
        gapCnt = 0;
      end
    end
  end

  function automatic int mrdOf(input logic [1:0] tgt);
    int m = 0;
    if (tgt[0] && MRD0 > m) m = MRD0;
    if (tgt[1] && MRD1 > m) m = MRD1;
    return m;
  endfunction

  task automatic pushEv(input logic [1:0] tgt, input logic [2:0] rcw, input logic [ADDR_W-1:0] a, input int gap, input string req);
    evT e;
    if (tgt == 2'b00) return;
    e.csN = ~tgt; e.rcw = rcw; e.addr = a; e.cke = ckeExp; e.gap = gap; e.req = req;
    expQ.push_back(e);
  endtask

  // Driver: predict, push expected items, apply the write, measure busy
  task automatic doCmd(input logic [2:0] mode, input logic [3:0] cnt, input logic [1:0] tgt,
                       input logic [ADDR_W-1:0] mr, input string req);
    int expBusy, n, reps;
    reps = 1;
    case (mode)
      3'd0, 3'd1: begin ckeExp = 1'b1; expBusy = 1; end
      3'd2: begin pushEv(tgt, 3'b010, 13'h400, 0, "R2 precharge"); expBusy = RP + 1; end
      3'd3: begin
        reps = (cnt == 0) ? 1 : int'(cnt);
        for (int i = 0; i < reps; i++) pushEv(tgt, 3'b001, '0, (i == 0) ? 0 : RC + 1, "R3 refresh");
        expBusy = reps * (RC + 1);
      end
      3'd4: begin pushEv(tgt, 3'b000, mr, 0, "R4 load mode"); expBusy = mrdOf(tgt) + 1; end
      3'd5: begin ckeExp = 1'b0; pushEv(tgt, 3'b001, '0, 0, "R8 self-refresh"); expBusy = 1; end
      3'd6: begin ckeExp = 1'b0; expBusy = 1; end
      default: expBusy = 1;
    endcase
    @(negedge clk);
    cmdMode = mode; cmdRefCnt = cnt; cmdTgt = tgt; cmdMrVal = mr; cmdWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == expBusy, {"R6 busy length ", req}, 32'(n), 32'(expBusy));
    chk(sdCke == ckeExp, {"R8 cke after ", req}, 32'(sdCke), 32'(ckeExp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sdCke == 0 && sdCsN == 2'b11, "R1 reset pins", {30'h0, sdCke, sdCsN[0]}, 32'h1);
    chk({sdRasN, sdCasN, sdWeN} == 3'b111, "R1 reset strobes", 32'({sdRasN, sdCasN, sdWeN}), 32'h7);
    chk(busy == 0 && wrErr == 0, "R1 reset status", {30'h0, busy, wrErr}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doCmd(3'd7, 0, 2'b11, '0, "R10 nop before enable");
    chk(sdCke == 0, "R8 cke low until enable", 32'(sdCke), 32'h0);
    doCmd(3'd1, 0, 2'b11, '0, "R8 clock enable");
    repeat (4) @(negedge clk);
    doCmd(3'd2, 0, 2'b11, '0, "R2 precharge both");
    doCmd(3'd3, 4'd8, 2'b11, '0, "R3 eight refreshes");
    doCmd(3'd4, 0, 2'b01, 13'h0231, "R4 load dev0");
    doCmd(3'd4, 0, 2'b10, 13'h1A5C, "R5 load dev1");
    doCmd(3'd4, 0, 2'b11, 13'h0033, "R6 load both");
    doCmd(3'd2, 0, 2'b10, '0, "R5 precharge dev1");
    doCmd(3'd3, 4'd0, 2'b01, '0, "R3 count zero");
    doCmd(3'd3, 4'd2, 2'b10, '0, "R3 count two");
    doCmd(3'd7, 0, 2'b11, '0, "R10 nop");

    // R9: write during busy is ignored and flagged
    chk(wrErr == 0, "R9 no error yet", 32'(wrErr), 32'h0);
    pushEv(2'b11, 3'b010, 13'h400, 0, "R9 precharge");
    @(negedge clk);
    cmdMode = 3'd2; cmdTgt = 2'b11; cmdWr = 1'b1;
    @(negedge clk);
    cmdMode = 3'd3; cmdRefCnt = 4'd3;
    @(negedge clk);
    cmdWr = 1'b0;
    begin
      int n = 1;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == RP + 1, "R9 busy not extended", 32'(n), 32'(RP + 1));
    end
    chk(wrErr == 1, "R9 error flag set", 32'(wrErr), 32'h1);

    doCmd(3'd5, 0, 2'b01, '0, "R8 self-refresh");
    doCmd(3'd0, 0, 2'b11, '0, "R8 normal exit");
    doCmd(3'd6, 0, 2'b11, '0, "R8 power-down");
    doCmd(3'd0, 0, 2'b11, '0, "R8 normal after power-down");
    chk(wrErr == 1, "R9 error sticky", 32'(wrErr), 32'h1);

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R7 all expected commands seen", 32'(expQ.size()), 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule